// File: doc/BRIEF.md
# Reset-Cause and Guarded Debug-Disable Register

This block is an 8-bit control and status register for a microcontroller. Five flag bits record which reset source acted most recently. A pulse from a reset source sets that source's flag, and software clears flags by writing zeros to them. The top bit turns the on-chip debug interface off. This bit is protected against stray writes: it takes a new value only after two writes of the same value that come close together in time.

Software writes the whole byte with a one-cycle strobe and reads it through a read strobe. The reset-source logic delivers one-cycle event pulses on the block's clock. The output `dbg_if_en_o` tells the debug port whether it may operate. That needs both the enable fuse and a clear disable bit.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst_ni` is asserted, every register bit is zero. A read therefore returns 0x00, and `dbg_if_en_o` equals `fuse_en_i`.
- R2: While `rd_en_i` is high, `rd_data_o` shows the register in the same cycle, with bits 6 and 5 always zero. While `rd_en_i` is low, `rd_data_o` is 0x00.
- R3: Bit 7 takes the value of `wr_data_i[7]` when a first write is followed by a second write carrying the same bit-7 value. If the first write is in cycle t, the second must fall in cycles t+1 to t+4. The new value is readable from the cycle after the second write.
- R4: In these cases bit 7 keeps its value: a lone write, a second write in cycle t+5 or later, and a second write inside the window with a different bit-7 value. A mismatch closes the window, so the next write only opens a new window.
- R5: `dbg_if_en_o` is high exactly when `fuse_en_i` is high and bit 7 is zero.
- R6: A one-cycle event pulse sets its flag, visible in the next cycle. The bit positions are: power-on bit 0, external bit 1, brown-out bit 2, watchdog bit 3, debug-port reset bit 4.
- R7: A power-on event sets bit 0 and clears bits 4 to 1. A bit whose own event arrives in the same cycle is not cleared. Bit 7 is not affected.
- R8: A write with a zero in flag bit n clears flag n. A one in that bit leaves the flag unchanged.
- R9: An event that arrives in the same cycle as a software clear of the same flag leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data |
| por_evt_i | input | 1 | Power-on reset event pulse |
| ext_evt_i | input | 1 | External reset event pulse |
| bod_evt_i | input | 1 | Brown-out reset event pulse |
| wdt_evt_i | input | 1 | Watchdog reset event pulse |
| dbg_evt_i | input | 1 | Debug-port reset event pulse |
| fuse_en_i | input | 1 | Debug enable fuse |
| dbg_if_en_o | output | 1 | Debug interface enable |

## Verification
The cases hardest to reach through the ports are the edges of the write window. These are a second write in exactly cycle t+4 (which commits) and in cycle t+5 (which only re-arms), and a mismatched write followed at once by a matching one. The directed sequences place writes on those exact cycles. Random stimulus then adds back-to-back write pairs with gaps from 0 to 5 cycles, so the window keeps opening, closing and committing. Rare event pulses land on the same cycles as flag-clearing writes.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned BIT_DIS = 7;
  localparam int unsigned SRC_POR = 0;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_BOD = 2;
  localparam int unsigned SRC_WDT = 3;
  localparam int unsigned SRC_DBG = 4;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rcr_timed_bit.sv
module rcr_timed_bit #(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic bit_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             val_q, val_d;
  logic             bit_q, bit_d;
  logic             armed_w;
  logic             val_en;

  assign armed_w = (cnt_q != '0);

  // window: arm on a first write, commit or abandon on the next write
  always_comb begin
    cnt_d  = armed_w ? cnt_q - 1'b1 : cnt_q;
    val_en = 1'b0;
    val_d  = wr_bit_i;
    bit_d  = bit_q;
    if (wr_en_i) begin
      if (armed_w) begin
        cnt_d = '0;
        if (wr_bit_i == val_q) bit_d = wr_bit_i;
      end else begin
        cnt_d  = CNT_W'(WIN_CYC);
        val_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      val_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      if (val_en) val_q <= val_d;
    end
  end

  assign bit_o = bit_q;

  assert_guarded_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_q) |-> ($past(wr_en_i) && $past(armed_w) && ($past(wr_bit_i) == $past(val_q))));

  assert_lone_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !armed_w) |=> $stable(bit_q));

  assert_second_write_disarms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && armed_w) |=> !armed_w);

  assert_arm_needs_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_w) |-> $past(wr_en_i));
endmodule

// File: rtl/rcr_cause_flags.sv
module rcr_cause_flags
  import rcr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t sw_clr_i,
  output src_vec_t flags_o
);
  src_vec_t flags_q, flags_d, clr_w;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    if (i == SRC_POR) begin : g_por
      assign clr_w[i] = sw_clr_i[i];
    end else begin : g_other
      assign clr_w[i] = sw_clr_i[i] | evt_i[SRC_POR];

      assert_por_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[SRC_POR] && !evt_i[i]) |=> !flags_q[i]);
    end

    // set dominates clear
    assign flags_d[i] = evt_i[i] | (flags_q[i] & ~clr_w[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[i] <= 1'b0;
      else         flags_q[i] <= flags_d[i];
    end

    assert_evt_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flags_q[i]);

    assert_flag_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[i] && !sw_clr_i[i] && !evt_i[SRC_POR]) |=> flags_q[i]);

    assert_sw_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_clr_i[i] && !evt_i[i]) |=> !flags_q[i]);

    assert_evt_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[i] && sw_clr_i[i]) |=> flags_q[i]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux
  import rcr_pkg::*;
(
  input  logic             rd_en_i,
  input  logic             dis_bit_i,
  input  src_vec_t         flags_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [REG_W-1:0] image_w;

  always_comb begin
    image_w               = '0;
    image_w[NUM_SRC-1:0]  = flags_i;
    image_w[BIT_DIS]      = dis_bit_i;
    rd_data_o             = rd_en_i ? image_w : '0;
  end

  always_comb begin
    assert_gap_bits_zero_R2: assert (rd_data_o[BIT_DIS-1:NUM_SRC] == '0);
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  input  logic       por_evt_i,
  input  logic       ext_evt_i,
  input  logic       bod_evt_i,
  input  logic       wdt_evt_i,
  input  logic       dbg_evt_i,
  input  logic       fuse_en_i,
  output logic       dbg_if_en_o
);
  src_vec_t evt_w, sw_clr_w, flags_w;
  logic     dis_w;

  always_comb begin
    evt_w          = '0;
    evt_w[SRC_POR] = por_evt_i;
    evt_w[SRC_EXT] = ext_evt_i;
    evt_w[SRC_BOD] = bod_evt_i;
    evt_w[SRC_WDT] = wdt_evt_i;
    evt_w[SRC_DBG] = dbg_evt_i;
    sw_clr_w       = wr_en_i ? ~wr_data_i[NUM_SRC-1:0] : '0;
  end

  rcr_timed_bit #(.WIN_CYC(WIN_CYC)) u_dis (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_bit_i(wr_data_i[BIT_DIS]),
    .bit_o   (dis_w)
  );

  rcr_cause_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_w),
    .sw_clr_i(sw_clr_w),
    .flags_o (flags_w)
  );

  rcr_read_mux u_rd (
    .rd_en_i  (rd_en_i),
    .dis_bit_i(dis_w),
    .flags_i  (flags_w),
    .rd_data_o(rd_data_o)
  );

  assign dbg_if_en_o = fuse_en_i & ~dis_w;

  assert_por_keeps_dis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_evt_i && !wr_en_i) |=> $stable(dis_w));
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_en_i, rd_en_i, fuse_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic       por_evt_i, ext_evt_i, bod_evt_i, wdt_evt_i, dbg_evt_i;
  logic       dbg_if_en_o;

  always #4 clk = ~clk;

  rst_cause_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .por_evt_i(por_evt_i),
    .ext_evt_i(ext_evt_i), .bod_evt_i(bod_evt_i), .wdt_evt_i(wdt_evt_i),
    .dbg_evt_i(dbg_evt_i), .fuse_en_i(fuse_en_i), .dbg_if_en_o(dbg_if_en_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_reg;
  int         m_cnt;
  bit         m_val;
  bit         m_fuse;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic void model(bit wr, logic [7:0] d, logic [4:0] ev);
    logic [7:0] nr = m_reg;
    if (wr) begin
      if (m_cnt > 0) begin
        if (d[7] == m_val) nr[7] = d[7];
        m_cnt = 0;
      end else begin
        m_cnt = 4;
        m_val = d[7];
      end
    end else if (m_cnt > 0) m_cnt--;
    for (int i = 0; i < 5; i++) begin
      bit clr = (wr && !d[i]) || (i != 0 && ev[0]);
      nr[i] = ev[i] | (m_reg[i] & ~clr);
    end
    m_reg = nr;
  endfunction

  task automatic step(string tag, bit wr, logic [7:0] d, logic [4:0] ev, bit fz);
    @(negedge clk);
    chk(tag, rd_data_o, m_reg);
    chk("R5", {7'd0, dbg_if_en_o}, {7'd0, m_fuse & ~m_reg[7]});
    wr_en_i = wr; wr_data_i = d; fuse_en_i = fz; m_fuse = fz;
    {dbg_evt_i, wdt_evt_i, bod_evt_i, ext_evt_i, por_evt_i} = ev;
    @(posedge clk);
    model(wr, d, ev);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(tag, 0, 8'h00, 5'd0, m_fuse);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 act=hung exp=finished (watchdog)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; wr_en_i = 0; rd_en_i = 1; fuse_en_i = 1; wr_data_i = 0;
    {dbg_evt_i, wdt_evt_i, bod_evt_i, ext_evt_i, por_evt_i} = 5'd0;
    m_reg = 8'h00; m_cnt = 0; m_val = 0; m_fuse = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1", rd_data_o, 8'h00);
    chk("R1", {7'd0, dbg_if_en_o}, 8'h01);
    // R2: read strobe low gives zero
    rd_en_i = 0; #1; chk("R2", rd_data_o, 8'h00); rd_en_i = 1;

    // R6: each source sets its own bit
    for (int i = 1; i < 5; i++) begin
      step("R6", 0, 8'h00, 5'(1 << i), 1);
      step("R6", 0, 8'h00, 5'd0, 1);
    end
    #1 chk("R6", rd_data_o, 8'h1E);
    // R8: write ones keeps, zero clears bit 2 only
    step("R8", 1, 8'h7B, 5'd0, 1);
    step("R8", 0, 8'h00, 5'd0, 1);
    #1 chk("R8", rd_data_o, 8'h1A);
    idle(6, "R8");
    // R7: power-on clears others, keeps coincident watchdog
    step("R7", 0, 8'h00, 5'b01001, 1);
    step("R7", 0, 8'h00, 5'd0, 1);
    #1 chk("R7", rd_data_o, 8'h09);
    // R9: event together with software clear of same bit
    step("R9", 1, 8'h00, 5'b00010, 1);
    step("R9", 0, 8'h00, 5'd0, 1);
    #1 chk("R9", rd_data_o, 8'h02);
    idle(6, "R9");

    // R4: lone write
    step("R4", 1, 8'h9F, 5'd0, 1);
    idle(6, "R4");
    #1 chk("R4", {7'd0, rd_data_o[7]}, 8'h00);
    // R3: second write at t+4 commits
    step("R3", 1, 8'h9F, 5'd0, 1);
    idle(3, "R3");
    step("R3", 1, 8'h9F, 5'd0, 1);
    step("R3", 0, 8'h00, 5'd0, 1);
    #1 chk("R3", {7'd0, rd_data_o[7]}, 8'h01);
    chk("R5", {7'd0, dbg_if_en_o}, 8'h00);
    idle(6, "R3");
    // R4: second write at t+5 only re-arms, third commits
    step("R4", 1, 8'h1F, 5'd0, 1);
    idle(4, "R4");
    step("R4", 1, 8'h1F, 5'd0, 1);
    step("R4", 0, 8'h00, 5'd0, 1);
    #1 chk("R4", {7'd0, rd_data_o[7]}, 8'h01);
    step("R3", 1, 8'h1F, 5'd0, 0);
    step("R3", 0, 8'h00, 5'd0, 0);
    #1 chk("R3", {7'd0, rd_data_o[7]}, 8'h00);
    chk("R5", {7'd0, dbg_if_en_o}, 8'h00);
    idle(6, "R5");
    // R4: mismatch disarms; next matching write only arms
    step("R4", 1, 8'h9F, 5'd0, 1);
    step("R4", 1, 8'h1F, 5'd0, 1);
    step("R4", 1, 8'h9F, 5'd0, 1);
    step("R4", 0, 8'h00, 5'd0, 1);
    #1 chk("R4", {7'd0, rd_data_o[7]}, 8'h00);
    idle(6, "R4");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] d  = 8'($urandom);
      logic [4:0] ev = ($urandom % 12 == 0) ? 5'($urandom) : 5'd0;
      bit fz = ($urandom % 20 == 0) ? ~m_fuse : m_fuse;
      if ($urandom % 4 != 0) ev[0] = 1'b0;
      if ($urandom % 5 == 0) begin
        int gap = $urandom % 6;
        step("R3", 1, d, ev, fz);
        idle(gap, "R4");
        step("R3", 1, ($urandom % 4 == 0) ? ~d : d, 5'd0, fz);
      end else begin
        step("R6", ($urandom % 3 == 0), d, ev, fz);
      end
    end
    idle(2, "R2");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule